// File: doc/BRIEF.md
# Callee-Register Stack Save Sequencer

This block carries out a register-save-to-stack operation for a 32-bit core. The caller gives it one instruction word, in either the compact 16-bit form or the full 32-bit form, along with the current stack pointer and a flag that marks the reduced core variant. The block decodes the first register, the number of registers, the stack decrement and the global-pointer option. It then walks the register list one entry at a time. For each entry it drives a register-file read index and issues a 32-bit store request. Each request is held until the memory side accepts it.

The stores go to word addresses just below the stack pointer that was latched at start, one word lower for each step. The list may run past register 31 and continue at register 16. When the global-pointer option is set, the final slot saves register 28 instead. The new stack pointer (the latched value minus the decrement) is written back only after every store has completed. A reserved-instruction fault, a misaligned stack pointer or an abort from the memory side ends the operation with an exception pulse and leaves the stack pointer untouched, so the instruction can be issued again.

Top module: `stksave_seq`

## Requirements
- R1: With `is_short`=1 only `insn[15:0]` is used. The first register is 31 when bit 9 is 1 and 30 when it is 0. The count is bits [3:0], the decrement is `{insn[7:4],4'b0000}`, and the global-pointer option is off.
- R2: With `is_short`=0 the first register is `insn[25:21]`, the count is `insn[19:16]`, the decrement is `{insn[11:3],3'b000}`, and the global-pointer option is `insn[2]`.
- R3: Step i (from 0) reads register rt+i when rt+i < 32, and rt+i-16 otherwise.
- R4: With the global-pointer option on, the last step (i = count-1) reads register 28.
- R5: Store i has address SP-4*(i+1), where SP is the stack pointer latched at start, and carries the value on `rf_data` for the index on `rf_idx`.
- R6: A store request holds `st_valid`, `st_addr` and `rf_idx` stable until `st_ready` is seen. The next store comes exactly 4 below the previous one.
- R7: A count of 0 issues no store. One cycle after start it pulses `done` and `sp_we`, with `sp_out` = SP - decrement.
- R8: The global-pointer option together with `reduced_core`=1 gives an `exc_valid` pulse with `exc_code`=1, no store and no `sp_we`.
- R9: With count > 0 and SP[1:0] != 0, the block issues no store and gives `exc_code`=2 with `exc_badva` = SP-4. Every address-error report has a misaligned `exc_badva`.
- R10: `abort` during a request ends the operation with `exc_code`=3, `exc_badva` = the pending address, and no `sp_we`.
- R11: After the last accepted store, `done` and `sp_we` pulse for exactly one cycle with `sp_out` = SP - decrement. `exc_valid` never coincides with `done` or `sp_we`.
- R12: After reset the block is idle with all outputs low. `start` is ignored while `busy` is high, and inputs other than `abort`, `st_ready` and `rf_data` are not used after start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation (taken only when idle) |
| is_short | input | 1 | 1: use the 16-bit form in insn[15:0] |
| insn | input | 32 | Instruction word |
| sp_in | input | 32 | Current stack pointer |
| reduced_core | input | 1 | Reduced variant: global-pointer option is reserved |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle success pulse |
| rf_idx | output | 5 | Register-file read index |
| rf_data | input | 32 | Register-file read data for rf_idx |
| st_valid | output | 1 | Store request valid |
| st_ready | input | 1 | Store accepted |
| st_addr | output | 32 | Store address |
| st_data | output | 32 | Store data |
| abort | input | 1 | Memory-side abort of the pending store |
| sp_we | output | 1 | Stack-pointer write enable |
| sp_out | output | 32 | New stack pointer |
| exc_valid | output | 1 | One-cycle exception pulse |
| exc_code | output | 2 | 1 reserved instruction, 2 address error, 3 abort |
| exc_badva | output | 32 | Faulting address |

## Verification
Some properties are checked on every cycle:
- A stalled request stays frozen, and each accepted store is followed by one exactly a word lower.
- An exception never comes with a stack-pointer write.
- Address-error reports always carry a misaligned address.
- No request is raised while idle.

Other behaviour only the bench's scenarios can show:
- The decode of both instruction forms.
- The wrap from 31 to 16 and the substitution of register 28.
- The final stack-pointer value.
- Abort part-way through a list.
- A start pulse that arrives while busy being ignored.

// File: rtl/stksave_pkg.sv
// Shared widths, operation record and exception codes for the stack save
// sequencer. Assumes a 32-entry register file and word-sized stores.
package stksave_pkg;
    localparam int XLEN_P   = 32;
    localparam int CNT_W    = 4;
    localparam int RIDX_W   = 5;
    localparam int DEC_W    = 12;
    localparam logic [RIDX_W-1:0] GP_REG    = 5'd28;
    localparam logic [RIDX_W:0]   WRAP_BACK = 6'd16;

    typedef enum logic [1:0] {
        EXC_NONE  = 2'd0,
        EXC_RSVD  = 2'd1,
        EXC_ALIGN = 2'd2,
        EXC_ABORT = 2'd3
    } exc_e;

    typedef struct packed {
        logic [RIDX_W-1:0] rt;
        logic [CNT_W-1:0]  cnt;
        logic [DEC_W-1:0]  dec;
        logic              gp;
    } save_op_t;
endpackage

// File: rtl/stksave_decode.sv
// Field extraction for both instruction forms. Purely combinational.
// Assumes the caller already dispatched on opcode; opcode bits are not checked.
module stksave_decode
    import stksave_pkg::*;
(
    input  logic [31:0] insn,
    input  logic        is_short,
    output save_op_t    op
);
    logic unused_opbits;

    // Pick first register, count, decrement and gp option per form.
    always_comb begin
        if (is_short) begin
            op.rt  = insn[9] ? 5'd31 : 5'd30;
            op.cnt = insn[3:0];
            op.dec = {4'b0000, insn[7:4], 4'b0000};
            op.gp  = 1'b0;
        end else begin
            op.rt  = insn[25:21];
            op.cnt = insn[19:16];
            op.dec = {insn[11:3], 3'b000};
            op.gp  = insn[2];
        end
    end

    assign unused_opbits = ^{insn[31:26], insn[20], insn[15:10], insn[8], insn[1:0]};
endmodule

// File: rtl/stksave_regsel.sv
// Register index for a list step: consecutive from rt, wrapping 31 -> 16,
// with register 28 substituted in the final slot when gp is set.
module stksave_regsel
    import stksave_pkg::*;
(
    input  logic [RIDX_W-1:0] rt,
    input  logic [CNT_W-1:0]  step,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              gp,
    output logic [RIDX_W-1:0] idx
);
    logic [RIDX_W:0] sum;
    logic [RIDX_W:0] wrapped;
    logic            last_slot;

    // Raw sum, wrap correction and gp substitution.
    always_comb begin
        sum       = {1'b0, rt} + {{(RIDX_W+1-CNT_W){1'b0}}, step};
        wrapped   = sum[RIDX_W] ? (sum - WRAP_BACK) : sum;
        last_slot = gp && (step == (cnt - 1'b1));
        idx       = last_slot ? GP_REG : wrapped[RIDX_W-1:0];
    end
endmodule

// File: rtl/stksave_seq.sv
// Top of the stack save sequencer. Latches the operation and stack pointer
// at start, then issues one valid/ready store per list entry at descending
// word addresses, and writes the new stack pointer only on full success.
// Assumes rf_data is an asynchronous read of rf_idx and the register file
// is not written while busy.
module stksave_seq
    import stksave_pkg::*;
#(
    parameter int XLEN = XLEN_P
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            is_short,
    input  logic [31:0]     insn,
    input  logic [XLEN-1:0] sp_in,
    input  logic            reduced_core,
    output logic            busy,
    output logic            done,
    output logic [RIDX_W-1:0] rf_idx,
    input  logic [XLEN-1:0] rf_data,
    output logic            st_valid,
    input  logic            st_ready,
    output logic [XLEN-1:0] st_addr,
    output logic [XLEN-1:0] st_data,
    input  logic            abort,
    output logic            sp_we,
    output logic [XLEN-1:0] sp_out,
    output logic            exc_valid,
    output logic [1:0]      exc_code,
    output logic [XLEN-1:0] exc_badva
);
    typedef enum logic {S_IDLE, S_REQ} state_e;

    state_e          state;
    save_op_t        op_dec, op_r;
    logic [CNT_W-1:0] step;
    logic [CNT_W:0]  step_inc;
    logic [XLEN-1:0] sp_r;
    logic            done_q, exc_q, last_step;
    exc_e            exc_code_q;
    logic [XLEN-1:0] badva_q, sp_out_q;

    stksave_decode u_dec (
        .insn     (insn),
        .is_short (is_short),
        .op       (op_dec)
    );

    stksave_regsel u_sel (
        .rt   (op_r.rt),
        .step (step),
        .cnt  (op_r.cnt),
        .gp   (op_r.gp),
        .idx  (rf_idx)
    );

    // Current store address and end-of-list detection.
    always_comb begin
        step_inc  = {1'b0, step} + 1'b1;
        st_addr   = sp_r - (XLEN'(step_inc) << 2);
        last_step = (step == (op_r.cnt - 1'b1));
    end

    // Sequencer: accept start, step through stores, finish or fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            op_r       <= '0;
            sp_r       <= '0;
            step       <= '0;
            done_q     <= 1'b0;
            exc_q      <= 1'b0;
            exc_code_q <= EXC_NONE;
            badva_q    <= '0;
            sp_out_q   <= '0;
        end else begin
            done_q <= 1'b0;
            exc_q  <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start) begin
                        op_r <= op_dec;
                        sp_r <= sp_in;
                        step <= '0;
                        if (op_dec.gp && reduced_core) begin
                            exc_q      <= 1'b1;
                            exc_code_q <= EXC_RSVD;
                            badva_q    <= '0;
                        end else if (op_dec.cnt == '0) begin
                            done_q   <= 1'b1;
                            sp_out_q <= sp_in - XLEN'(op_dec.dec);
                        end else if (sp_in[1:0] != 2'b00) begin
                            exc_q      <= 1'b1;
                            exc_code_q <= EXC_ALIGN;
                            badva_q    <= sp_in - XLEN'(4);
                        end else begin
                            state <= S_REQ;
                        end
                    end
                end
                S_REQ: begin
                    if (abort) begin
                        exc_q      <= 1'b1;
                        exc_code_q <= EXC_ABORT;
                        badva_q    <= st_addr;
                        state      <= S_IDLE;
                    end else if (st_ready) begin
                        if (last_step) begin
                            done_q   <= 1'b1;
                            sp_out_q <= sp_r - XLEN'(op_r.dec);
                            state    <= S_IDLE;
                        end else begin
                            step <= step + 1'b1;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Output wiring.
    assign busy      = (state != S_IDLE);
    assign st_valid  = (state == S_REQ);
    assign st_data   = rf_data;
    assign done      = done_q;
    assign sp_we     = done_q;
    assign sp_out    = sp_out_q;
    assign exc_valid = exc_q;
    assign exc_code  = exc_code_q;
    assign exc_badva = badva_q;

    AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid && !st_ready && !abort |=> st_valid && $stable(st_addr) && $stable(rf_idx)); // R6
    AST_STORE_DESCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid && st_ready && !abort |=> !st_valid || (st_addr == $past(st_addr) - XLEN'(4))); // R5
    AST_FAULT_NO_SPWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> !sp_we && !done); // R11
    AST_ALIGN_BADVA: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid && (exc_code == 2'd2) |-> (exc_badva[1:0] != 2'b00)); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !st_valid); // R12
endmodule

// File: tb/sim_stksave_seq.sv
module sim_stksave_seq;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        sh;
        logic [31:0] insn;
        logic [31:0] sp;
        logic        red;
        logic [1:0]  exc;
        logic [31:0] res;   // new SP, or bad address on fault
        logic [4:0]  nst;   // stores expected to complete
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 32'hDEAD1E33, 32'h0000_1000, 1'b0, 2'd0, 32'h0000_0FD0, 5'd3},
        '{1'b1, 32'h0000_1C10, 32'h0000_2000, 1'b0, 2'd0, 32'h0000_1FF0, 5'd0},
        '{1'b0, 32'h83C4_3104, 32'h0000_8000, 1'b0, 2'd0, 32'h0000_7F00, 5'd4},
        '{1'b0, 32'h83C4_3104, 32'h0000_8000, 1'b1, 2'd1, 32'h0000_0000, 5'd0},
        '{1'b0, 32'h820F_3FF8, 32'h0001_0000, 1'b0, 2'd0, 32'h0000_F008, 5'd15},
        '{1'b1, 32'h0000_1E33, 32'h0000_1002, 1'b0, 2'd2, 32'h0000_0FFE, 5'd0},
        '{1'b0, 32'h80A2_3008, 32'h0000_0400, 1'b0, 2'd0, 32'h0000_03F8, 5'd2},
        '{1'b0, 32'h83EF_3004, 32'h0000_3000, 1'b0, 2'd0, 32'h0000_3000, 5'd15}
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, is_short = 1'b0, reduced_core = 1'b0;
    logic [31:0] insn = '0, sp_in = '0;
    logic st_ready = 1'b0, abort = 1'b0;
    logic busy, done, st_valid, sp_we, exc_valid;
    logic [4:0] rf_idx;
    logic [31:0] rf_data, st_addr, st_data, sp_out, exc_badva;
    logic [1:0] exc_code;
    int n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign rf_data = 32'hA500_0000 | ({27'd0, rf_idx} * 32'h111);

    stksave_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .is_short(is_short), .insn(insn),
        .sp_in(sp_in), .reduced_core(reduced_core), .busy(busy), .done(done),
        .rf_idx(rf_idx), .rf_data(rf_data), .st_valid(st_valid), .st_ready(st_ready),
        .st_addr(st_addr), .st_data(st_data), .abort(abort), .sp_we(sp_we),
        .sp_out(sp_out), .exc_valid(exc_valid), .exc_code(exc_code), .exc_badva(exc_badva)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] want_idx(int rt, int i, int cnt, bit gp);
        int t;
        if (gp && (i == cnt - 1)) return 5'd28;
        t = rt + i;
        if (t >= 32) t = t - 16;
        return t[4:0];
    endfunction

    // Run one operation; abort_at = store number to abort on (-1 none),
    // poke = raise start with another word while busy.
    task automatic run_op(input vec_t v, input int abort_at, input bit poke);
        int k = 0, cyc = 0, rt, cnt;
        bit gp, fin = 0, prev_stall = 0;
        logic [31:0] prev_addr = '0;
        logic [31:0] exp_d;
        string tag;
        if (v.sh) begin rt = v.insn[9] ? 31 : 30; cnt = int'(v.insn[3:0]); gp = 0; end
        else begin rt = int'(v.insn[25:21]); cnt = int'(v.insn[19:16]); gp = v.insn[2]; end
        @(negedge clk);
        insn = v.insn; is_short = v.sh; sp_in = v.sp; reduced_core = v.red; start = 1'b1;
        @(negedge clk);
        start = 1'b0; sp_in = 32'hFFFF_FFF0; insn = 32'h0;   // R12: later inputs unused
        while (!fin && cyc < 300) begin
            st_ready = 1'b0; abort = 1'b0; start = 1'b0;
            if (done || exc_valid) begin
                fin = 1;
                chk(k == int'(v.nst), "R5 store count", k, {27'd0, v.nst});
                if (v.exc == 2'd0) begin
                    tag = (v.nst == 0) ? "R7" : (v.sh ? "R1" : "R2");
                    chk(done && sp_we && !exc_valid, tag, {29'd0, done, sp_we, exc_valid}, 32'h6);
                    chk(sp_out == v.res, tag, sp_out, v.res);
                end else begin
                    tag = (v.exc == 2'd1) ? "R8" : ((v.exc == 2'd2) ? "R9" : "R10");
                    chk(exc_valid && !sp_we && !done && exc_code == v.exc, tag,
                        {27'd0, exc_valid, sp_we, done, exc_code}, {27'd0, 3'b100, v.exc});
                    if (v.exc != 2'd1) chk(exc_badva == v.res, tag, exc_badva, v.res);
                end
            end else begin
                if (st_valid) begin
                    if (prev_stall) chk(st_addr == prev_addr, "R6 hold", st_addr, prev_addr);
                    chk(st_addr == v.sp - 32'(4 * (k + 1)), "R5 addr", st_addr, v.sp - 32'(4 * (k + 1)));
                    tag = (gp && k == cnt - 1) ? "R4" : "R3";
                    chk(rf_idx == want_idx(rt, k, cnt, gp), tag, {27'd0, rf_idx}, {27'd0, want_idx(rt, k, cnt, gp)});
                    exp_d = 32'hA500_0000 | ({27'd0, want_idx(rt, k, cnt, gp)} * 32'h111);
                    chk(st_data == exp_d, "R5 data", st_data, exp_d);
                    if (k == abort_at) abort = 1'b1;
                    else st_ready = ((cyc % 3) != 1);
                    prev_stall = !st_ready && !abort;
                    prev_addr  = st_addr;
                    if (st_ready) k++;
                end else prev_stall = 0;
                if (poke && cyc == 2) begin
                    chk(busy, "R12 busy", {31'd0, busy}, 32'd1);
                    start = 1'b1; insn = 32'h80A2_3008; is_short = 1'b0; sp_in = 32'h400;
                end
            end
            @(negedge clk);
            cyc++;
        end
        st_ready = 1'b0; abort = 1'b0; start = 1'b0;
        chk(fin, "R11 completion", {31'd0, fin}, 32'd1);
        chk(!done && !sp_we && !exc_valid && !busy, "R11 pulse",
            {28'd0, done, sp_we, exc_valid, busy}, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        vec_t av;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(!busy && !st_valid && !done && !sp_we && !exc_valid, "R12 reset",
            {27'd0, busy, st_valid, done, sp_we, exc_valid}, 32'd0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) run_op(VECS[i], -1, 1'b0);
        // R10: abort on the second store of a three-store list
        av = VECS[0];
        av.exc = 2'd3; av.nst = 5'd1; av.res = 32'h0000_0FF8;
        run_op(av, 1, 1'b0);
        // R12: start while busy is ignored; the original op completes
        run_op(VECS[4], -1, 1'b1);
        // R12: mid-run reset returns to idle
        @(negedge clk); insn = 32'h820F_3FF8; is_short = 1'b0; sp_in = 32'h1_0000; start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk(!busy && !st_valid && !done && !exc_valid, "R12 reset mid-run",
            {28'd0, busy, st_valid, done, exc_valid}, 32'd0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule